// File: doc/BRIEF.md
# Per-Lane Instruction Lifecycle Tracker

This block keeps the lifecycle state of the vector instructions that are in flight inside one lane. Every instruction occupies one of a fixed number of slots, selected by a small identifier. For each slot the block holds a running flag. It also produces a done flag that is raised when the slot finishes.

When the lane's dispatcher asks to start a slot, the request is honoured only if that slot is idle. A slot that is already running is never started a second time. The integer unit and the floating-point unit each report completion through their own valid/identifier pair. Both can report in the same cycle, and both reports are kept.

Every slot that finishes is reported to the central sequencer for exactly one cycle through a done vector. In that same cycle the slot's running flag drops.

Top module: `lane_life_tracker`

## Requirements
- R1: With `rst_i` high at a rising clock edge, `running_o`, `done_o` and `start_o` are all zero after that edge.
- R2: A start request (`start_req_i` high) for slot k whose running bit is 0 sets `running_o[k]` after the edge. In the same cycle it pulses `start_o` for one cycle, with `start_id_o` equal to k.
- R3: A start request for a slot whose running bit is already 1 is suppressed. `start_o` stays 0 and `running_o` is unchanged.
- R4: An integer completion (`int_cpl_i` high, slot `int_cpl_id_i`) for a running slot k gives `done_o[k]`=1 for exactly one cycle after the edge. In that same cycle `running_o[k]` reads 0.
- R5: A floating-point completion (`fp_cpl_i`, `fp_cpl_id_i`) for a running slot behaves exactly as in R4.
- R6: Completions from both units in the same cycle for two different running slots are both recorded: two done bits in the same cycle, and both running bits cleared. If both units name the same slot, only that one done bit is raised.
- R7: A completion that names a slot whose running bit is 0 is ignored. No done bit is raised and `running_o` is unchanged.
- R8: Bit k of `running_o` and `done_o` belongs to identifier k. A start and a completion on different slots in the same cycle each take effect, and other slots stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_req_i | input | 1 | Request to start a slot |
| start_id_i | input | 3 | Slot to start |
| int_cpl_i | input | 1 | Integer unit completion strobe |
| int_cpl_id_i | input | 3 | Slot completed by the integer unit |
| fp_cpl_i | input | 1 | Floating-point unit completion strobe |
| fp_cpl_id_i | input | 3 | Slot completed by the floating-point unit |
| start_o | output | 1 | Registered pulse: the request was accepted |
| start_id_o | output | 3 | Slot accepted, valid while start_o is high |
| running_o | output | 8 | Running flag per slot |
| done_o | output | 8 | One-cycle completion pulse per slot |

## Verification
Every internal flag of this block is visible directly on `running_o` and `done_o`, one edge after the event that changes it. A corrupted running bit therefore shows within one cycle, in either of two ways:
- `start_o` is missing, or appears twice, for that slot.
- A completion is dropped, or raised when it should not be.

A lost merge of the two completion paths shows as a single done bit where two were expected. A done flag that is held too long shows as a pulse wider than one cycle. The directed scenarios place each of these events one cycle apart and compare all outputs after every edge.

// File: rtl/lane_life_pkg.sv
package lane_life_pkg;
  localparam int unsigned SLOTS = 8;
  localparam int unsigned ID_W  = $clog2(SLOTS);
  typedef logic [ID_W-1:0]  slot_id_t;
  typedef logic [SLOTS-1:0] slot_vec_t;
endpackage

// File: rtl/lane_life_dec.sv
module lane_life_dec #(
  parameter int unsigned N   = 8,
  parameter int unsigned ID_W = $clog2(N)
) (
  input  logic            en_i,
  input  logic [ID_W-1:0] id_i,
  output logic [N-1:0]    hot_o
);
  always_comb begin
    hot_o = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i && (id_i == ID_W'(i))) hot_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/lane_life_slot.sv
module lane_life_slot (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic running_o,
  output logic done_o
);
  logic run_q, done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= clr_i & run_q;
      if (set_i)                run_q <= 1'b1;
      else if (clr_i && run_q)  run_q <= 1'b0;
    end
  end

  assign running_o = run_q;
  assign done_o    = done_q;

  // R4 R5: a done pulse coincides with a cleared running flag
  a_r4_done_clears_run: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |-> !run_q);
  // R4: done is a single-cycle pulse
  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> !done_q);
  // R2: a slot only becomes running because of an accepted start
  a_r2_rise_needs_set: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(run_q) |-> $past(set_i));
  // R7: a completion on an idle slot leaves it idle without a done pulse
  a_r7_idle_cpl_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !run_q && !set_i) |=> (!done_q && !run_q));
endmodule

// File: rtl/lane_life_tracker.sv
module lane_life_tracker
  import lane_life_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_req_i,
  input  logic [ID_W-1:0] start_id_i,
  input  logic            int_cpl_i,
  input  logic [ID_W-1:0] int_cpl_id_i,
  input  logic            fp_cpl_i,
  input  logic [ID_W-1:0] fp_cpl_id_i,
  output logic            start_o,
  output logic [ID_W-1:0] start_id_o,
  output logic [SLOTS-1:0] running_o,
  output logic [SLOTS-1:0] done_o
);
  slot_vec_t run_vec, done_vec, req_hot, int_hot, fp_hot, set_vec, clr_vec;
  logic      accept;
  logic      start_q;
  slot_id_t  start_id_q;

  lane_life_dec #(.N(SLOTS), .ID_W(ID_W)) u_dec_req (
    .en_i(start_req_i), .id_i(start_id_i), .hot_o(req_hot));
  lane_life_dec #(.N(SLOTS), .ID_W(ID_W)) u_dec_int (
    .en_i(int_cpl_i), .id_i(int_cpl_id_i), .hot_o(int_hot));
  lane_life_dec #(.N(SLOTS), .ID_W(ID_W)) u_dec_fp (
    .en_i(fp_cpl_i), .id_i(fp_cpl_id_i), .hot_o(fp_hot));

  // start-once guard: only idle slots may be started
  assign set_vec = req_hot & ~run_vec;
  assign accept  = |set_vec;
  // merge both completion sources
  assign clr_vec = int_hot | fp_hot;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    lane_life_slot u_slot (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .set_i    (set_vec[s]),
      .clr_i    (clr_vec[s]),
      .running_o(run_vec[s]),
      .done_o   (done_vec[s])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_q    <= 1'b0;
      start_id_q <= '0;
    end else begin
      start_q    <= accept;
      start_id_q <= start_id_i;
    end
  end

  assign start_o    = start_q;
  assign start_id_o = start_id_q;
  assign running_o  = run_vec;
  assign done_o     = done_vec;

  // R1: reset empties all state
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (running_o == '0 && done_o == '0 && !start_o));
  // R2: an accepted slot is running when its start pulse appears
  a_r2_started_is_running: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |-> running_o[start_id_o]);
  // R3: a request to a running slot never produces a start pulse
  a_r3_no_double_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_req_i && running_o[start_id_i]) |=> !start_o);
  // R6: two units finishing two running slots give two done bits
  a_r6_dual_cpl: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_cpl_i && fp_cpl_i && int_cpl_id_i != fp_cpl_id_i &&
     running_o[int_cpl_id_i] && running_o[fp_cpl_id_i]) |=> ($countones(done_o) == 2));
  // R4 R5: at most two slots can finish in one cycle
  a_r5_done_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(done_o) <= 2);
endmodule

// File: tb/lane_life_tracker_tb_top.sv
module lane_life_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       req, iv, fv;
  logic [2:0] rid, iid, fid;
  logic       start;
  logic [2:0] start_id;
  logic [7:0] running, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_run = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  lane_life_tracker dut_i (
    .clk_i(clk), .rst_i(rst),
    .start_req_i(req), .start_id_i(rid),
    .int_cpl_i(iv), .int_cpl_id_i(iid),
    .fp_cpl_i(fv), .fp_cpl_id_i(fid),
    .start_o(start), .start_id_o(start_id),
    .running_o(running), .done_o(done)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at negedge, check outputs at the following negedge
  task automatic cyc(input string tag, input logic r, input logic [2:0] ri,
                     input logic a, input logic [2:0] ai,
                     input logic b, input logic [2:0] bi);
    logic [7:0] exp_done;
    logic acc;
    req = r; rid = ri; iv = a; iid = ai; fv = b; fid = bi;
    acc = r && !exp_run[ri];
    exp_done = '0;
    if (a && exp_run[ai]) exp_done[ai] = 1'b1;
    if (b && exp_run[bi]) exp_done[bi] = 1'b1;
    exp_run = exp_run & ~exp_done;
    if (acc) exp_run[ri] = 1'b1;
    @(negedge clk);
    check(tag, "running", running, exp_run);
    check(tag, "done", done, exp_done);
    check(tag, "start", start, acc);
    if (acc) check(tag, "start_id", start_id, ri);
    req = 0; iv = 0; fv = 0;
  endtask

  task automatic do_reset(input string tag);
    rst = 1; req = 0; iv = 0; fv = 0; rid = 0; iid = 0; fid = 0;
    @(negedge clk);
    rst = 0;
    exp_run = '0;
    check(tag, "running", running, 0);
    check(tag, "done", done, 0);
    check(tag, "start", start, 0);
  endtask

  task automatic t_start();            // R2
    cyc("R2", 1, 3'd2, 0, 0, 0, 0);
    cyc("R2", 1, 3'd7, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_double();           // R3
    cyc("R3", 1, 3'd2, 0, 0, 0, 0);
    cyc("R3", 1, 3'd7, 0, 0, 0, 0);
  endtask

  task automatic t_int();              // R4
    cyc("R4", 0, 0, 1, 3'd2, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 0);
    cyc("R4", 1, 3'd2, 0, 0, 0, 0);    // restart after completion allowed
  endtask

  task automatic t_fp();               // R5
    cyc("R5", 0, 0, 0, 0, 1, 3'd7);
    cyc("R5", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_dual();             // R6
    cyc("R6", 1, 3'd5, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 3'd2, 1, 3'd5);
    cyc("R6", 1, 3'd1, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 3'd1, 1, 3'd1);
  endtask

  task automatic t_idle();             // R7
    cyc("R7", 0, 0, 1, 3'd4, 1, 3'd6);
    cyc("R7", 1, 3'd4, 1, 3'd4, 0, 0); // start and completion of idle slot together
    cyc("R7", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mixed();            // R8
    cyc("R8", 1, 3'd0, 0, 0, 1, 3'd4);
    cyc("R8", 1, 3'd3, 1, 3'd0, 0, 0);
    cyc("R8", 1, 3'd6, 1, 3'd3, 1, 3'd6);
  endtask

  task automatic t_reset_mid();        // R1
    cyc("R1", 1, 3'd1, 0, 0, 0, 0);
    do_reset("R1");
  endtask

  initial begin
    do_reset("R1");
    t_start();
    t_double();
    t_int();
    t_fp();
    t_dual();
    t_idle();
    t_mixed();
    t_reset_mid();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule